// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches a free-running system counter supplied from outside and escalates in two steps when software stops servicing it. The block holds an absolute 64-bit compare value. Each service operation ("kick") reloads that value with the current counter plus a programmable 32-bit offset. If the counter reaches the compare value, the block raises a warning interrupt and arms a second period of the same length. If that second period also runs out, the block asserts a reset request.

Software reaches the block over a simple single-cycle register bus with two select lines. One select line chooses the control frame and the other chooses the kick frame. Read data is combinational in the cycle of the access. Writes take effect at the clock edge.

A four-state machine sequences the escalation:
- IDLE: disabled, nothing advances.
- ARMED: waiting for the first expiry.
- WARNED: warning raised, waiting for the second expiry.
- FIRED: reset requested.

The transitions are:
- IDLE→ARMED: a control write with the enable bit set.
- any→IDLE: a control write with the enable bit clear.
- ARMED→WARNED: the first expiry.
- WARNED→FIRED: the second expiry.
- WARNED/FIRED→ARMED: any kick while enabled.

The stage-1 status bit is kept in a flop with its own clear input, so it survives the system reset that it caused.

Top module: `wdog2_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, the machine is IDLE: `irq_warn` and `rst_req` are low, and the offset and compare registers read 0.
- R2: A kick reloads the compare value with counter plus offset and clears both stage flags. A kick is any of:
  - a write of any data to kick-frame offset 0x000;
  - any write to control offset 0x000;
  - any write to control offset 0x008. For this write the newly written offset is used.

  An enabled machine then returns to ARMED.
- R3: In ARMED, when a clock edge finds counter >= compare (unsigned), the machine moves to WARNED. `irq_warn` is high from that edge on, and compare is reloaded with counter plus offset.
- R4: In WARNED, when a clock edge finds counter >= compare, the machine moves to FIRED. `rst_req` goes high and stays high, with `irq_warn` also high, until a kick, a disable or `rst_n`.
- R5: The control/status word at control offset 0x000 has this layout:
  - bit 0 is enable, written from write data bit 0;
  - bit 1 is the stage-0 flag (WARNED or FIRED);
  - bit 2 is the stage-1 flag;
  - all other bits read 0.

  Writing 0 to this word disables the block.
- R6: While disabled, the counter never advances a stage, and `irq_warn` and `rst_req` stay low.
- R7: Software can write the compare value directly without a kick. Control offset 0x010 holds the low 32 bits and 0x014 holds the high 32 bits. Both read back, and the written value sets the next expiry point.
- R8: Reads and writes follow this address map:
  - control offset 0x008 is the offset register, read/write;
  - offset 0xFCC returns the `IMPL_ID` parameter and 0xFD0 returns the `PERIPH_ID` parameter, in both frames;
  - every other offset reads 0;
  - writes to other offsets change nothing. This includes kick-frame offsets other than 0x000.
- R9: The stage-1 flag is set on entry to FIRED. It is not cleared by `rst_n`, only by a kick or by `cause_rst_n` low. `rst_req` is low whenever the machine is not FIRED, even if the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of machine, offset and compare |
| cause_rst_n | input | 1 | Active-low asynchronous clear of the stage-1 flag only |
| sys_cnt | input | CNT_W | Free-running system counter value |
| bus_ctl_sel | input | 1 | Selects the control frame for this cycle's access |
| bus_rfr_sel | input | 1 | Selects the kick frame for this cycle's access |
| bus_we | input | 1 | Write strobe; low means read |
| bus_addr | input | ADDR_W | Byte offset within the selected frame |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| irq_warn | output | 1 | Stage-0 warning interrupt |
| rst_req | output | 1 | Stage-1 reset request |

## Verification
The bench builds the block with its default widths: a 64-bit counter and compare, a 32-bit offset and data bus, and 12-bit offsets. It sets two recognisable identification values. Because the counter is an input that the bench drives directly, each expiry is reached in a single step by placing the counter one tick before or exactly on the compare value. This also allows jumps far past the compare value, and it reaches the compare high word without long runs. The default widths also bring the split compare halves within reach. Writing the high half makes the next expiry unreachable, which shows that escalation is governed by the full 64-bit comparison.

// File: rtl/wdog2_pkg.sv
package wdog2_pkg;

    // Escalation states of the watchdog
    typedef enum logic [1:0] {
        WD_IDLE   = 2'd0,
        WD_ARMED  = 2'd1,
        WD_WARNED = 2'd2,
        WD_FIRED  = 2'd3
    } wd_state_e;

    // Byte offsets inside the two frames
    localparam int unsigned OFS_CTRL  = 32'h000;
    localparam int unsigned OFS_OFFS  = 32'h008;
    localparam int unsigned OFS_CMPL  = 32'h010;
    localparam int unsigned OFS_CMPH  = 32'h014;
    localparam int unsigned OFS_IMPL  = 32'hFCC;
    localparam int unsigned OFS_PERI  = 32'hFD0;
    localparam int unsigned OFS_KICK  = 32'h000;

    // Control/status bit positions
    localparam int unsigned BIT_EN  = 0;
    localparam int unsigned BIT_WS0 = 1;
    localparam int unsigned BIT_WS1 = 2;

endpackage

// File: rtl/wdog2_fsm.sv
module wdog2_fsm
    import wdog2_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refresh,
    input  logic             ctl_wr,
    input  logic             en_val,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             stage0_fire,
    output logic             stage1_fire,
    output logic             en_flag,
    output logic             ws0_flag,
    output logic             irq_warn,
    output logic             rst_req
);

    wd_state_e state_q;
    wd_state_e state_d;
    logic      expired;

    assign expired = (cnt >= cmp);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and stage events
    always_comb begin
        state_d     = state_q;
        stage0_fire = 1'b0;
        stage1_fire = 1'b0;
        if (refresh) begin
            if (ctl_wr) begin
                state_d = en_val ? WD_ARMED : WD_IDLE;
            end else begin
                state_d = (state_q == WD_IDLE) ? WD_IDLE : WD_ARMED;
            end
        end else begin
            unique case (state_q)
                WD_IDLE: begin
                    state_d = WD_IDLE;
                end
                WD_ARMED: begin
                    if (expired) begin
                        state_d     = WD_WARNED;
                        stage0_fire = 1'b1;
                    end
                end
                WD_WARNED: begin
                    if (expired) begin
                        state_d     = WD_FIRED;
                        stage1_fire = 1'b1;
                    end
                end
                WD_FIRED: begin
                    state_d = WD_FIRED;
                end
            endcase
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        en_flag  = (state_q != WD_IDLE);
        ws0_flag = (state_q == WD_WARNED) || (state_q == WD_FIRED);
        irq_warn = ws0_flag;
        rst_req  = (state_q == WD_FIRED);
    end

    AST_FIRE_NEEDS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> irq_warn); // R4
    AST_FIRED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_FIRED && !refresh) |=> (state_q == WD_FIRED)); // R4
    AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (!irq_warn && !rst_req)); // R2
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_IDLE && !ctl_wr) |=> (state_q == WD_IDLE)); // R6
    AST_WARN_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_warn) |-> $past(expired)); // R3

endmodule

// File: rtl/wdog2_regs.sv
module wdog2_regs
    import wdog2_pkg::*;
#(
    parameter int unsigned CNT_W     = 64,
    parameter int unsigned OFF_W     = 32,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 32,
    parameter logic [31:0] IMPL_ID   = 32'h0000_0001,
    parameter logic [31:0] PERIPH_ID = 32'h0000_0002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cause_rst_n,
    input  logic              ctl_sel,
    input  logic              rfr_sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              stage0_fire,
    input  logic              stage1_fire,
    input  logic              en_flag,
    input  logic              ws0_flag,
    output logic              refresh,
    output logic              ctl_wr,
    output logic [CNT_W-1:0]  cmp
);

    localparam int unsigned HI_W = CNT_W - DATA_W;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_OFFS = ADDR_W'(OFS_OFFS);
    localparam logic [ADDR_W-1:0] A_CMPL = ADDR_W'(OFS_CMPL);
    localparam logic [ADDR_W-1:0] A_CMPH = ADDR_W'(OFS_CMPH);
    localparam logic [ADDR_W-1:0] A_IMPL = ADDR_W'(OFS_IMPL);
    localparam logic [ADDR_W-1:0] A_PERI = ADDR_W'(OFS_PERI);
    localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(OFS_KICK);

    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] off_nxt;
    logic [CNT_W-1:0] cmp_q;
    logic             ws1_sticky;
    logic             off_wr;
    logic             cmpl_wr;
    logic             cmph_wr;
    logic             kick_wr;

    // Write decode
    always_comb begin
        ctl_wr  = ctl_sel && we && (addr == A_CTRL);
        off_wr  = ctl_sel && we && (addr == A_OFFS);
        cmpl_wr = ctl_sel && we && (addr == A_CMPL);
        cmph_wr = ctl_sel && we && (addr == A_CMPH);
        kick_wr = rfr_sel && we && (addr == A_KICK);
        refresh = ctl_wr || off_wr || kick_wr;
        off_nxt = off_wr ? wdata[OFF_W-1:0] : off_q;
    end

    // Offset register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (off_wr) begin
            off_q <= wdata[OFF_W-1:0];
        end
    end

    // Compare register: kick, direct halves, stage-0 reload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (refresh) begin
            cmp_q <= cnt + CNT_W'(off_nxt);
        end else if (cmpl_wr) begin
            cmp_q[DATA_W-1:0] <= wdata;
        end else if (cmph_wr) begin
            cmp_q[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
        end else if (stage0_fire) begin
            cmp_q <= cnt + CNT_W'(off_q);
        end
    end

    assign cmp = cmp_q;

    // Stage-1 flag survives the system reset
    always_ff @(posedge clk or negedge cause_rst_n) begin
        if (!cause_rst_n) begin
            ws1_sticky <= 1'b0;
        end else if (refresh) begin
            ws1_sticky <= 1'b0;
        end else if (stage1_fire) begin
            ws1_sticky <= 1'b1;
        end
    end

    // Read mux
    always_comb begin
        rdata = '0;
        if (ctl_sel) begin
            if (addr == A_CTRL) begin
                rdata[BIT_EN]  = en_flag;
                rdata[BIT_WS0] = ws0_flag;
                rdata[BIT_WS1] = ws1_sticky;
            end else if (addr == A_OFFS) begin
                rdata = DATA_W'(off_q);
            end else if (addr == A_CMPL) begin
                rdata = cmp_q[DATA_W-1:0];
            end else if (addr == A_CMPH) begin
                rdata = DATA_W'(cmp_q[CNT_W-1:DATA_W]);
            end else if (addr == A_IMPL) begin
                rdata = DATA_W'(IMPL_ID);
            end else if (addr == A_PERI) begin
                rdata = DATA_W'(PERIPH_ID);
            end
        end else if (rfr_sel) begin
            if (addr == A_IMPL) begin
                rdata = DATA_W'(IMPL_ID);
            end else if (addr == A_PERI) begin
                rdata = DATA_W'(PERIPH_ID);
            end
        end
    end

    AST_STICKY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n || !cause_rst_n)
        stage1_fire |=> ws1_sticky); // R9
    AST_KICK_CLEARS_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !cause_rst_n)
        refresh |=> !ws1_sticky); // R2
    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh && !cmpl_wr && !cmph_wr && !stage0_fire) |=> $stable(cmp_q)); // R7
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_wr, off_wr, cmpl_wr, cmph_wr})); // R8

endmodule

// File: rtl/wdog2_top.sv
module wdog2_top
    import wdog2_pkg::*;
#(
    parameter int unsigned CNT_W     = 64,
    parameter int unsigned OFF_W     = 32,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 32,
    parameter logic [31:0] IMPL_ID   = 32'h0000_0001,
    parameter logic [31:0] PERIPH_ID = 32'h0000_0002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cause_rst_n,
    input  logic [CNT_W-1:0]  sys_cnt,
    input  logic              bus_ctl_sel,
    input  logic              bus_rfr_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_warn,
    output logic              rst_req
);

    logic             refresh;
    logic             ctl_wr;
    logic [CNT_W-1:0] cmp;
    logic             stage0_fire;
    logic             stage1_fire;
    logic             en_flag;
    logic             ws0_flag;

    wdog2_regs #(
        .CNT_W     (CNT_W),
        .OFF_W     (OFF_W),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .IMPL_ID   (IMPL_ID),
        .PERIPH_ID (PERIPH_ID)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cause_rst_n (cause_rst_n),
        .ctl_sel     (bus_ctl_sel),
        .rfr_sel     (bus_rfr_sel),
        .we          (bus_we),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .rdata       (bus_rdata),
        .cnt         (sys_cnt),
        .stage0_fire (stage0_fire),
        .stage1_fire (stage1_fire),
        .en_flag     (en_flag),
        .ws0_flag    (ws0_flag),
        .refresh     (refresh),
        .ctl_wr      (ctl_wr),
        .cmp         (cmp)
    );

    wdog2_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .refresh     (refresh),
        .ctl_wr      (ctl_wr),
        .en_val      (bus_wdata[BIT_EN]),
        .cnt         (sys_cnt),
        .cmp         (cmp),
        .stage0_fire (stage0_fire),
        .stage1_fire (stage1_fire),
        .en_flag     (en_flag),
        .ws0_flag    (ws0_flag),
        .irq_warn    (irq_warn),
        .rst_req     (rst_req)
    );

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_flag && !refresh) |=> (!irq_warn && !rst_req)); // R6

endmodule

// File: tb/wdog2_top_bench.sv
module wdog2_top_bench;

    localparam logic [31:0] T_IMPL = 32'h0001_A55A;
    localparam logic [31:0] T_PERI = 32'h0000_0B17;

    localparam logic [2:0] OP_SC = 3'd0; // set counter, step, check outputs
    localparam logic [2:0] OP_WC = 3'd1; // write control frame
    localparam logic [2:0] OP_WR = 3'd2; // write kick frame
    localparam logic [2:0] OP_RC = 3'd3; // read control frame, check
    localparam logic [2:0] OP_RR = 3'd4; // read kick frame, check

    typedef struct packed {
        logic [2:0]  op;
        logic [11:0] addr;
        logic [63:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t VEC [NV] = '{
        '{OP_SC, 12'h000, 64'd1000, 32'd0,    8'd6}, // R6 disabled
        '{OP_WC, 12'h008, 64'd100,  32'd0,    8'd2}, // R2 offset write kicks
        '{OP_RC, 12'h010, 64'd0,    32'd1100, 8'd2}, // R2
        '{OP_RC, 12'h014, 64'd0,    32'd0,    8'd2}, // R2
        '{OP_RC, 12'h008, 64'd0,    32'd100,  8'd8}, // R8
        '{OP_WC, 12'h000, 64'd1,    32'd0,    8'd5}, // R5 enable
        '{OP_RC, 12'h000, 64'd0,    32'd1,    8'd5}, // R5
        '{OP_SC, 12'h000, 64'd1099, 32'd0,    8'd3}, // R3 one tick before
        '{OP_SC, 12'h000, 64'd1100, 32'd1,    8'd3}, // R3 match
        '{OP_RC, 12'h000, 64'd0,    32'd3,    8'd5}, // R5
        '{OP_RC, 12'h010, 64'd0,    32'd1200, 8'd3}, // R3 reload
        '{OP_WR, 12'h004, 64'd0,    32'd0,    8'd8}, // R8 not a kick
        '{OP_SC, 12'h000, 64'd1100, 32'd1,    8'd8}, // R8
        '{OP_WR, 12'h000, 64'hDEAD, 32'd0,    8'd2}, // R2 kick
        '{OP_SC, 12'h000, 64'd1150, 32'd0,    8'd2}, // R2
        '{OP_RC, 12'h000, 64'd0,    32'd1,    8'd2}, // R2
        '{OP_SC, 12'h000, 64'd1250, 32'd1,    8'd3}, // R3 jump past
        '{OP_SC, 12'h000, 64'd1349, 32'd1,    8'd4}, // R4
        '{OP_SC, 12'h000, 64'd1350, 32'd3,    8'd4}, // R4 fire
        '{OP_RC, 12'h000, 64'd0,    32'd7,    8'd4}, // R4
        '{OP_SC, 12'h000, 64'd5000, 32'd3,    8'd4}, // R4 holds
        '{OP_WC, 12'h004, 64'd0,    32'd0,    8'd8}, // R8 undefined write
        '{OP_SC, 12'h000, 64'd5000, 32'd3,    8'd8}, // R8
        '{OP_WC, 12'h000, 64'd0,    32'd0,    8'd5}, // R5 disable
        '{OP_SC, 12'h000, 64'd5001, 32'd0,    8'd6}, // R6
        '{OP_SC, 12'h000, 64'd9000, 32'd0,    8'd6}, // R6 no advance
        '{OP_RC, 12'h000, 64'd0,    32'd0,    8'd6}, // R6
        '{OP_WC, 12'h000, 64'd1,    32'd0,    8'd7}, // R7 enable
        '{OP_WC, 12'h010, 64'd9500, 32'd0,    8'd7}, // R7 low half
        '{OP_RC, 12'h010, 64'd0,    32'd9500, 8'd7}, // R7
        '{OP_SC, 12'h000, 64'd9400, 32'd0,    8'd7}, // R7
        '{OP_SC, 12'h000, 64'd9500, 32'd1,    8'd7}, // R7
        '{OP_WC, 12'h014, 64'd1,    32'd0,    8'd7}, // R7 high half
        '{OP_RC, 12'h014, 64'd0,    32'd1,    8'd7}, // R7
        '{OP_SC, 12'h000, 64'd9700, 32'd1,    8'd7}, // R7
        '{OP_WC, 12'h008, 64'd50,   32'd0,    8'd2}, // R2 offset kick
        '{OP_SC, 12'h000, 64'd9700, 32'd0,    8'd2}, // R2
        '{OP_RC, 12'h010, 64'd0,    32'd9750, 8'd2}, // R2
        '{OP_RC, 12'h014, 64'd0,    32'd0,    8'd2}, // R2
        '{OP_RC, 12'h004, 64'd0,    32'd0,    8'd8}, // R8
        '{OP_RC, 12'h100, 64'd0,    32'd0,    8'd8}, // R8
        '{OP_RR, 12'h008, 64'd0,    32'd0,    8'd8}, // R8
        '{OP_RR, 12'h000, 64'd0,    32'd0,    8'd8}, // R8
        '{OP_RR, 12'hFCC, 64'd0,    T_IMPL,   8'd8}, // R8
        '{OP_RC, 12'hFD0, 64'd0,    T_PERI,   8'd8}, // R8
        '{OP_RR, 12'hFD0, 64'd0,    T_PERI,   8'd8}  // R8
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cause_rst_n;
    logic [63:0] sys_cnt;
    logic        bus_ctl_sel;
    logic        bus_rfr_sel;
    logic        bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_warn;
    logic        rst_req;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    wdog2_top #(
        .IMPL_ID   (T_IMPL),
        .PERIPH_ID (T_PERI)
    ) u_wdog2_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .cause_rst_n (cause_rst_n),
        .sys_cnt     (sys_cnt),
        .bus_ctl_sel (bus_ctl_sel),
        .bus_rfr_sel (bus_rfr_sel),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_warn    (irq_warn),
        .rst_req     (rst_req)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp,
                       input int req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_idle();
        bus_ctl_sel = 1'b0;
        bus_rfr_sel = 1'b0;
        bus_we      = 1'b0;
        bus_addr    = '0;
        bus_wdata   = '0;
    endtask

    task automatic wr(input logic ctl, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_ctl_sel = ctl;
        bus_rfr_sel = !ctl;
        bus_we      = 1'b1;
        bus_addr    = a;
        bus_wdata   = d;
        @(negedge clk);
        bus_idle();
    endtask

    task automatic rd(input logic ctl, input logic [11:0] a, input logic [31:0] e,
                      input int req);
        @(negedge clk);
        bus_ctl_sel = ctl;
        bus_rfr_sel = !ctl;
        bus_we      = 1'b0;
        bus_addr    = a;
        #2;
        chk(64'(bus_rdata), 64'(e), req, $sformatf("read %s 0x%03h", ctl ? "ctl" : "kick", a));
        bus_idle();
    endtask

    task automatic setcnt(input logic [63:0] v, input logic [1:0] e, input int req);
        @(negedge clk);
        sys_cnt = v;
        @(negedge clk);
        chk(64'({rst_req, irq_warn}), 64'(e), req,
            $sformatf("outputs {rst_req,irq_warn} at cnt %0d", v));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired, run hung");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        cause_rst_n = 1'b0;
        sys_cnt     = '0;
        bus_idle();
        repeat (3) @(negedge clk);
        rst_n       = 1'b1;
        cause_rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(64'({rst_req, irq_warn}), 64'd0, 1, "outputs after reset");
        rd(1'b1, 12'h000, 32'd0, 1); // R1
        rd(1'b1, 12'h008, 32'd0, 1); // R1
        rd(1'b1, 12'h010, 32'd0, 1); // R1

        // vector table
        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i].op)
                OP_SC: setcnt(VEC[i].data, VEC[i].exp[1:0], int'(VEC[i].req));
                OP_WC: wr(1'b1, VEC[i].addr, VEC[i].data[31:0]);
                OP_WR: wr(1'b0, VEC[i].addr, VEC[i].data[31:0]);
                OP_RC: rd(1'b1, VEC[i].addr, VEC[i].exp, int'(VEC[i].req));
                OP_RR: rd(1'b0, VEC[i].addr, VEC[i].exp, int'(VEC[i].req));
                default: ;
            endcase
        end

        // R9 flag survives system reset, cleared by its own input
        setcnt(64'd9750, 2'b01, 3);  // R3
        setcnt(64'd9800, 2'b11, 4);  // R4
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(64'({rst_req, irq_warn}), 64'd0, 1, "outputs in system reset"); // R1
        rd(1'b1, 12'h000, 32'd4, 9);  // R9
        rd(1'b1, 12'h008, 32'd0, 1);  // R1
        @(negedge clk);
        rst_n = 1'b1;
        rd(1'b1, 12'h000, 32'd4, 9);  // R9
        setcnt(64'd20000, 2'b00, 9);  // R9 flag alone raises nothing
        @(negedge clk);
        cause_rst_n = 1'b0;
        @(negedge clk);
        cause_rst_n = 1'b1;
        rd(1'b1, 12'h000, 32'd0, 9);  // R9

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule